// File: doc/BRIEF.md
# PHY Configuration Serial Command Master

This block writes or reads one 16-bit configuration word in a PHY over a dedicated two-wire serial link. Software fills a small set of byte registers with a 7-bit target device address, an 8-bit register index and a two-byte data word. It then writes a command byte whose bit 1 requests a write and whose bit 0 requests a read. The block runs the whole serial transaction on its own. It drives the clock line and pulls the open-drain data line low when needed. It ends every command with exactly one completion indication or one failure indication.

The indications are one-cycle pulses meant for an interrupt controller. The same events also latch into a two-bit status byte that is cleared by writing ones to it. A driver can therefore poll the two low status bits until one of them is set. A read returns the received word through two read-only byte registers. The bit rate comes from a parameterised divider of the system clock. Each quarter of a serial clock period lasts `CLK_DIV` system clocks.

Top module: `phy_cfg_i2c_master`

## Requirements
- R1: After reset, and whenever no command is running, `scl_o` is high and `sda_oe_o` is low. After reset `busy_o` is low, the status byte is 0 and every byte register reads 0.
- R2: Register map, with 16-bit addresses. 0x3020 holds the device address in bits 6:0 and reads bit 7 as 0. 0x3021 is the register index. 0x3022 and 0x3023 are the write-data high and low bytes. 0x3024 and 0x3025 are the read-data high and low bytes (read-only). 0x3026 is the command byte. 0x0108 is the status byte. Writable registers read back what was written.
- R3: A write command sends, in order: START, the byte {device, 0}, the register index, the data high byte and the data low byte, each followed by an acknowledge bit sampled from the target. It then sends STOP. Bytes go out MSB first.
- R4: A read command sends START, {device, 0} and the register index. It then sends a repeated START and {device, 1}. It then receives two bytes MSB first, driving ACK (low) after the first byte and NACK (released) after the second. It ends with STOP. The first byte appears at 0x3024 and the second at 0x3025.
- R5: Each command ends with exactly one one-cycle pulse: `done_o` on success or `err_o` on failure. Each pulse sets its own status bit (bit 1 for done, bit 0 for error). Writing a 1 to a status bit at 0x0108 clears it. A set in the same cycle wins over a clear.
- R6: A NACK on any byte the master sends stops the transfer. The block sends no further byte, issues STOP and pulses `err_o` instead of `done_o`.
- R7: `sda_oe_o` changes while `scl_o` stays high only to form a START (falling data) or a STOP (rising data).
- R8: Every high phase of `scl_o` within a command lasts 2*CLK_DIV system clocks.
- R9: A command write arriving while `busy_o` is high is ignored.
- R10: A command byte with bit 1 set starts a write, even if bit 0 is also set. A command byte with bit 1 clear and bit 0 set starts a read. A command byte with both bits clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register address for write and read |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| irq_stat_o | output | 2 | Latched status, bit 1 done, bit 0 error |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| sda_i | input | 1 | Sensed data line level |

## Verification
The risks are a wrong sequence step, a wrong bit counter or a wrong phase counter. Any of these shows at the target as a shifted or truncated byte, a missing or extra START, or a data edge while the clock is high. The bench model catches it within the same command. A lost abort flag shows when the command finishes, as a done pulse where an error was due, or as extra bytes after a refused one. Bad read-data capture shows when 0x3024 and 0x3025 are read after the command ends.

// File: rtl/phy_i2c_pkg.sv
package phy_i2c_pkg;
  localparam logic [15:0] A_DEV  = 16'h3020;
  localparam logic [15:0] A_REG  = 16'h3021;
  localparam logic [15:0] A_WHI  = 16'h3022;
  localparam logic [15:0] A_WLO  = 16'h3023;
  localparam logic [15:0] A_RHI  = 16'h3024;
  localparam logic [15:0] A_RLO  = 16'h3025;
  localparam logic [15:0] A_OP   = 16'h3026;
  localparam logic [15:0] A_STAT = 16'h0108;

  typedef enum logic [1:0] {U_START, U_STOP, U_TX, U_RX} unit_e;

  typedef struct packed {
    logic [6:0]  dev;
    logic [7:0]  regad;
    logic [15:0] wdata;
  } cmd_t;
endpackage

// File: rtl/phy_i2c_tick.sv
module phy_i2c_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = run_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/phy_i2c_regs.sv
module phy_i2c_regs
  import phy_i2c_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        busy_i,
  input  logic        done_i,
  input  logic        err_i,
  input  logic [15:0] rd_word_i,
  output cmd_t        cmd_o,
  output logic        start_o,
  output logic        start_rd_o,
  output logic [1:0]  stat_o
);
  logic [6:0] dev_q;
  logic [7:0] reg_q, whi_q, wlo_q;
  logic [1:0] stat_q;
  logic [1:0] clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q <= '0;
      reg_q <= '0;
      whi_q <= '0;
      wlo_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_DEV:   dev_q <= wdata_i[6:0];
        A_REG:   reg_q <= wdata_i;
        A_WHI:   whi_q <= wdata_i;
        A_WLO:   wlo_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr = (wr_i && addr_i == A_STAT) ? wdata_i[1:0] : 2'b00;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | {done_i, err_i};
  end

  assign start_o    = wr_i && (addr_i == A_OP) && !busy_i && (wdata_i[1] || wdata_i[0]);
  assign start_rd_o = !wdata_i[1];
  assign cmd_o      = '{dev: dev_q, regad: reg_q, wdata: {whi_q, wlo_q}};
  assign stat_o     = stat_q;

  always_comb begin
    case (addr_i)
      A_DEV:   rdata_o = {1'b0, dev_q};
      A_REG:   rdata_o = reg_q;
      A_WHI:   rdata_o = whi_q;
      A_WLO:   rdata_o = wlo_q;
      A_RHI:   rdata_o = rd_word_i[15:8];
      A_RLO:   rdata_o = rd_word_i[7:0];
      A_STAT:  rdata_o = {6'b0, stat_q};
      default: rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/phy_i2c_seq.sv
module phy_i2c_seq
  import phy_i2c_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        start_i,
  input  logic        start_rd_i,
  input  cmd_t        cmd_i,
  input  logic        sda_i,
  output logic        busy_o,
  output logic        scl_o,
  output logic        sda_oe_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rd_word_o,
  output unit_e       unit_o
);
  localparam logic [3:0] ACK_BIT = 4'd8;

  logic       busy_q, rd_q, nack_q, scl_q, oe_q;
  logic [2:0] step_q;
  logic [3:0] bitn_q;
  logic [1:0] ph_q;
  logic [7:0] sh_q, rhi_q, rlo_q;
  cmd_t       cmd_q;
  unit_e      unit;
  logic [7:0] txb;
  logic [2:0] stop_step;

  always_comb begin
    if (rd_q) begin
      case (step_q)
        3'd0, 3'd3:       unit = U_START;
        3'd1, 3'd2, 3'd4: unit = U_TX;
        3'd5, 3'd6:       unit = U_RX;
        default:          unit = U_STOP;
      endcase
    end else begin
      case (step_q)
        3'd0:                   unit = U_START;
        3'd1, 3'd2, 3'd3, 3'd4: unit = U_TX;
        default:                unit = U_STOP;
      endcase
    end
  end

  always_comb begin
    case (step_q)
      3'd1:    txb = {cmd_q.dev, 1'b0};
      3'd2:    txb = cmd_q.regad;
      3'd3:    txb = cmd_q.wdata[15:8];
      3'd4:    txb = rd_q ? {cmd_q.dev, 1'b1} : cmd_q.wdata[7:0];
      default: txb = 8'h00;
    endcase
  end

  assign stop_step = rd_q ? 3'd7 : 3'd5;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      nack_q <= 1'b0;
      scl_q  <= 1'b1;
      oe_q   <= 1'b0;
      step_q <= '0;
      bitn_q <= '0;
      ph_q   <= '0;
      sh_q   <= '0;
      rhi_q  <= '0;
      rlo_q  <= '0;
      cmd_q  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        rd_q   <= start_rd_i;
        cmd_q  <= cmd_i;
        nack_q <= 1'b0;
        step_q <= '0;
        bitn_q <= '0;
        ph_q   <= '0;
      end else if (busy_q && tick_i) begin
        ph_q <= ph_q + 2'd1;
        case (unit)
          U_START: begin
            case (ph_q)
              2'd0: begin scl_q <= 1'b0; oe_q <= 1'b0; end
              2'd1: scl_q <= 1'b1;
              2'd2: oe_q <= 1'b1;
              default: begin scl_q <= 1'b0; step_q <= step_q + 3'd1; end
            endcase
          end
          U_STOP: begin
            case (ph_q)
              2'd0: begin scl_q <= 1'b0; oe_q <= 1'b1; end
              2'd1: scl_q <= 1'b1;
              2'd2: oe_q <= 1'b0;
              default: begin
                busy_q <= 1'b0;
                done_o <= !nack_q;
                err_o  <= nack_q;
              end
            endcase
          end
          U_TX: begin
            case (ph_q)
              2'd0: begin
                scl_q <= 1'b0;
                oe_q  <= (bitn_q < ACK_BIT) ? !txb[3'd7 - bitn_q[2:0]] : 1'b0;
              end
              2'd1: scl_q <= 1'b1;
              2'd2: if (bitn_q == ACK_BIT && sda_i) nack_q <= 1'b1;
              default: begin
                scl_q <= 1'b0;
                if (bitn_q == ACK_BIT) begin
                  bitn_q <= '0;
                  step_q <= nack_q ? stop_step : step_q + 3'd1;
                end else begin
                  bitn_q <= bitn_q + 4'd1;
                end
              end
            endcase
          end
          default: begin // U_RX
            case (ph_q)
              2'd0: begin
                scl_q <= 1'b0;
                // ACK after first byte, release (NACK) after last
                oe_q  <= (bitn_q == ACK_BIT) && (step_q == 3'd5);
              end
              2'd1: scl_q <= 1'b1;
              2'd2: if (bitn_q < ACK_BIT) sh_q <= {sh_q[6:0], sda_i};
              default: begin
                scl_q <= 1'b0;
                if (bitn_q == ACK_BIT) begin
                  bitn_q <= '0;
                  step_q <= step_q + 3'd1;
                  if (step_q == 3'd5) rhi_q <= sh_q;
                  else                rlo_q <= sh_q;
                end else begin
                  bitn_q <= bitn_q + 4'd1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  assign busy_o    = busy_q;
  assign scl_o     = scl_q;
  assign sda_oe_o  = oe_q;
  assign rd_word_o = {rhi_q, rlo_q};
  assign unit_o    = unit;
endmodule

// File: rtl/phy_cfg_i2c_master.sv
module phy_cfg_i2c_master
  import phy_i2c_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [1:0]  irq_stat_o,
  output logic        scl_o,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  cmd_t        cmd;
  logic        start, start_rd, tick;
  logic [15:0] rd_word;
  unit_e       unit;
  logic        cond_unit;

  phy_i2c_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy_o),
    .done_i     (done_o),
    .err_i      (err_o),
    .rd_word_i  (rd_word),
    .cmd_o      (cmd),
    .start_o    (start),
    .start_rd_o (start_rd),
    .stat_o     (irq_stat_o)
  );

  phy_i2c_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .clr_i  (start),
    .tick_o (tick)
  );

  phy_i2c_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .start_i    (start),
    .start_rd_i (start_rd),
    .cmd_i      (cmd),
    .sda_i      (sda_i),
    .busy_o     (busy_o),
    .scl_o      (scl_o),
    .sda_oe_o   (sda_oe_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .rd_word_o  (rd_word),
    .unit_o     (unit)
  );

  assign cond_unit = (unit == U_START) || (unit == U_STOP);
endmodule

// File: rtl/phy_cfg_i2c_chk.sv
module phy_cfg_i2c_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       done_i,
  input logic       err_i,
  input logic [1:0] stat_i,
  input logic       scl_i,
  input logic       sda_oe_i,
  input logic       cond_i
);
  // R5
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && err_i));

  // R5
  end_of_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i || err_i) |-> ($past(busy_i) && !busy_i));

  // R5
  done_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_i[1]);

  // R5
  err_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> stat_i[0]);

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (scl_i && !sda_oe_i));

  // R7
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !cond_i && !$past(cond_i)) |-> $stable(sda_oe_i));
endmodule

bind phy_cfg_i2c_master phy_cfg_i2c_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_o),
  .done_i   (done_o),
  .err_i    (err_o),
  .stat_i   (irq_stat_o),
  .scl_i    (scl_o),
  .sda_oe_i (sda_oe_o),
  .cond_i   (cond_unit)
);

// File: tb/sim_phy_cfg_i2c_master.sv
module sim_phy_cfg_i2c_master;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        busy, done, err, scl, sda_oe;
  logic [1:0]  stat;
  logic        slv_pull = 1'b0;
  logic        sda_bus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  assign sda_bus = !(sda_oe || slv_pull);

  always #4 clk = !clk;

  phy_cfg_i2c_master #(.CLK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .busy_o(busy),
    .done_o(done), .err_o(err), .irq_stat_o(stat), .scl_o(scl),
    .sda_oe_o(sda_oe), .sda_i(sda_bus)
  );

  // target model configuration (bench-owned)
  int         nack_abs = -1;
  logic [7:0] sbyte0 = '0, sbyte1 = '0;

  // target model state (model-owned)
  int         starts = 0, stops = 0, bidx = 0, bcnt = 0, sidx = 0;
  logic [7:0] cap [0:63];
  logic       mack [0:1];
  logic [7:0] shift = '0;
  bit         sending = 0, is_addr = 0, rd_req = 0;
  logic       last_scl = 1'b1, last_oe = 1'b0;

  always @(scl or sda_oe) begin
    if (scl && last_scl && sda_oe && !last_oe) begin
      starts++; bcnt = -1; is_addr = 1;
    end else if (scl && last_scl && !sda_oe && last_oe) begin
      stops++;
    end else if (scl && !last_scl) begin
      if (!sending && bcnt < 8) shift = {shift[6:0], sda_bus};
      if (sending && bcnt == 8) mack[sidx] = sda_bus;
    end else if (!scl && last_scl) begin
      bcnt++;
      if (bcnt == 8) begin
        if (!sending) begin
          cap[bidx % 64] = shift;
          slv_pull = (bidx != nack_abs);
          rd_req = is_addr && shift[0] && (bidx != nack_abs);
          is_addr = 0;
        end else slv_pull = 1'b0;
      end else if (bcnt == 9) begin
        bcnt = 0; slv_pull = 1'b0;
        if (!sending) begin
          bidx++;
          if (rd_req) begin sending = 1; sidx = 0; rd_req = 0; end
        end else begin
          sidx++;
          if (sidx == 2) sending = 0;
        end
        if (sending) slv_pull = !((sidx == 0) ? sbyte0[7] : sbyte1[7]);
      end else if (sending && bcnt >= 0 && bcnt < 8) begin
        slv_pull = !((sidx == 0) ? sbyte0[7-bcnt] : sbyte1[7-bcnt]);
      end
    end
    last_scl = scl; last_oe = sda_oe;
  end

  // pulse counters and clock/data timing monitors
  int ndone = 0, nerr = 0, nhi = 0, bad_hi = 0, hi_cnt = 0, sda_hi_chg = 0;
  bit hi_act = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) ndone++;
      if (err)  nerr++;
      if (scl && p_scl && sda_bus != p_sda) sda_hi_chg++;
      if (scl && !p_scl) begin hi_act = busy; hi_cnt = 1; end
      else if (scl) hi_cnt++;
      else if (p_scl && hi_act) begin
        nhi++;
        if (hi_cnt != 2*DIV) bad_hi++;
        hi_act = 0;
      end
      if (!busy) hi_act = 0;
      p_scl = scl; p_sda = sda_bus;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] dv, input logic r);
    return {dv, r};
  endfunction

  // one command against the target model; k = refused byte index or -1
  task automatic run_cmd(input bit is_rd, input logic [6:0] dv, input logic [7:0] ra,
                         input logic [7:0] hi, input logic [7:0] lo, input int k);
    int b0 = bidx, s0 = starts, p0 = stops, d0 = ndone, e0 = nerr;
    int nbytes;
    logic [7:0] v;
    nack_abs = (k < 0) ? -1 : b0 + k;
    sbyte0 = hi; sbyte1 = lo;
    wr(16'h3020, {1'b0, dv});
    wr(16'h3021, ra);
    if (!is_rd) begin wr(16'h3022, hi); wr(16'h3023, lo); end
    wr(16'h3026, is_rd ? 8'h01 : 8'h02);
    chk("R9 busy after command", busy, 1);
    wait_idle();
    @(negedge clk);
    nbytes = (k >= 0) ? k + 1 : (is_rd ? 3 : 4);
    chk(is_rd ? "R4 byte count" : "R3 byte count", bidx - b0, nbytes);
    chk("R3 addr byte", cap[b0 % 64], addr_byte(dv, 1'b0));
    if (nbytes > 1) chk("R3 reg byte", cap[(b0+1) % 64], ra);
    if (!is_rd && nbytes > 2) chk("R3 hi byte", cap[(b0+2) % 64], hi);
    if (!is_rd && nbytes > 3) chk("R3 lo byte", cap[(b0+3) % 64], lo);
    if (is_rd && nbytes > 2) chk("R4 addr-R byte", cap[(b0+2) % 64], addr_byte(dv, 1'b1));
    chk("R3 stops", stops - p0, 1);
    chk(is_rd ? "R4 starts" : "R3 starts", starts - s0, (is_rd && (k < 0 || k == 2)) ? 2 : 1);
    if (k >= 0) begin
      chk("R6 err pulses", nerr - e0, 1);
      chk("R6 no done", ndone - d0, 0);
      chk("R5 status error", stat, 2'b01);
    end else begin
      chk("R5 done pulses", ndone - d0, 1);
      chk("R5 no err", nerr - e0, 0);
      chk("R5 status done", stat, 2'b10);
      if (is_rd) begin
        chk("R4 master ack first", mack[0], 1'b0);
        chk("R4 master nack last", mack[1], 1'b1);
        rd(16'h3024, v); chk("R4 read hi", v, hi);
        rd(16'h3025, v); chk("R4 read lo", v, lo);
      end
    end
    wr(16'h0108, 8'h03);
    @(negedge clk);
    chk("R5 status cleared", stat, 2'b00);
  endtask

  initial begin
    logic [7:0] v;
    int s0, d0;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl idle", scl, 1);
    chk("R1 sda released", sda_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 status", stat, 0);
    rd(16'h3020, v); chk("R1 dev reg", v, 0);
    rd(16'h3025, v); chk("R1 read lo", v, 0);

    wr(16'h3020, 8'hFF); rd(16'h3020, v); chk("R2 dev 7 bits", v, 8'h7F);
    wr(16'h3021, 8'hA5); rd(16'h3021, v); chk("R2 reg index", v, 8'hA5);
    wr(16'h3022, 8'h3C); rd(16'h3022, v); chk("R2 write hi", v, 8'h3C);
    wr(16'h3023, 8'hC3); rd(16'h3023, v); chk("R2 write lo", v, 8'hC3);

    // directed
    run_cmd(0, 7'h69, 8'h06, 8'h00, 8'hA0, -1);
    run_cmd(1, 7'h69, 8'h15, 8'hFF, 8'h00, -1);
    run_cmd(0, 7'h12, 8'h10, 8'h81, 8'h7E, 0);
    run_cmd(0, 7'h12, 8'h10, 8'h81, 8'h7E, 3);
    run_cmd(1, 7'h55, 8'h09, 8'h5A, 8'hA5, 2);

    // R10: zero command starts nothing
    s0 = starts;
    wr(16'h3026, 8'h00);
    repeat (20) @(negedge clk);
    chk("R10 zero op idle", busy, 0);
    chk("R10 zero op no start", starts - s0, 0);

    // R10: both bits -> write; R9: command while busy ignored
    s0 = starts; d0 = ndone;
    wr(16'h3020, 8'h2A); wr(16'h3021, 8'h0E);
    wr(16'h3026, 8'h03);
    repeat (30) @(negedge clk);
    wr(16'h3026, 8'h01);
    wait_idle();
    @(negedge clk);
    chk("R10 both bits write", cap[(bidx-4) % 64], addr_byte(7'h2A, 1'b0));
    chk("R9 one start only", starts - s0, 1);
    chk("R9 one done only", ndone - d0, 1);
    repeat (20) @(negedge clk);
    chk("R9 stays idle", busy, 0);
    wr(16'h0108, 8'h03);

    // random
    for (int i = 0; i < 12; i++) begin
      bit r = $urandom_range(1, 0) == 1;
      int k = ($urandom_range(3, 0) == 0) ? int'($urandom_range(r ? 2 : 3, 0)) : -1;
      run_cmd(r, 7'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), k);
    end

    chk("R8 high phases seen", (nhi > 0), 1);
    chk("R8 high phase length", bad_hi, 0);
    chk("R7 data edges under high clock", sda_hi_chg, starts + stops);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule